// File: doc/BRIEF.md
# Transmit FIFO with Watermark Status

This block is the transmit-side byte queue of a serial port. Software pushes one byte per write strobe on the write-data path. A downstream serializer removes bytes through a ready/valid pop port, but only while the transmit-enable input is high. The block keeps registered full and empty flags and a readable fill level. It also produces two indications for an interrupt controller: a watermark condition tied to a programmable threshold, and a one-cycle pulse when the queue has been drained to zero.

The FIFO control write port carries two things. The first is a 3-bit threshold code. The second is a clear bit that discards every queued byte at once. A byte written while the queue is full is dropped, and a one-cycle overflow pulse reports the loss. All flags, the level and the event outputs are registered. They change on the clock edge that ends the cycle in which the causing strobe was presented. Reset is synchronous and active high.

Top module: `tx_fifo_wm`

## Requirements
- R1: Each cycle with `wdata_we_i` high and no clear stores `wdata_i` and raises `level_o` (5 bits, 0..16) by one at the next edge, unless R2 applies.
- R2: A write while the queue holds 16 bytes and no pop fires in that cycle is dropped. The level is unchanged and `ovf_o` is high for exactly the following cycle.
- R3: `full_o` is high exactly when the level is 16. It clears on the edge that completes a pop from a full queue.
- R4: `empty_o` is high exactly when the level is 0. Any accepted write clears it.
- R5: `tx_empty_evt_o` pulses for one cycle when a pop with no accepted write takes the level from 1 to 0. A clear does not pulse it.
- R6: The threshold code maps to a level as follows: 0 gives 1, 1 gives 4, 2 gives 8, and codes 3 to 7 give 12. The code is loaded by `fctl_we_i`, is 0 after reset, and takes effect for the cycle in which it is written.
- R7: `tx_wm_o` rises only on an accepted write that leaves the level at or above the threshold. It falls as soon as the level is below the threshold, and otherwise holds.
- R8: A cycle with `fctl_we_i` and `fctl_txrst_i` both high empties the queue at the next edge. A write in that same cycle is discarded without an overflow pulse.
- R9: `pop_valid_o` is high only when `tx_enable_i` is high and the queue is not empty. Bytes leave on `pop_data_o` in the order they were written, one per cycle with `pop_ready_i` high.
- R10: A write and a pop in the same cycle leave the level unchanged. This includes a write to a full queue, which is then accepted.
- R11: After reset the level is 0, `empty_o` is 1, and `full_o`, `tx_wm_o`, `tx_empty_evt_o` and `ovf_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable_i | input | 1 | Allows the serializer to pop |
| wdata_we_i | input | 1 | Write strobe for one byte |
| wdata_i | input | 8 | Byte to queue |
| fctl_we_i | input | 1 | FIFO control write strobe |
| fctl_txrst_i | input | 1 | Clear bit of the control write |
| fctl_thr_i | input | 3 | Threshold code of the control write |
| pop_ready_i | input | 1 | Serializer accepts the head byte |
| pop_valid_o | output | 1 | Head byte available |
| pop_data_o | output | 8 | Head byte |
| level_o | output | 5 | Current fill level |
| full_o | output | 1 | Queue holds 16 bytes |
| empty_o | output | 1 | Queue holds no byte |
| tx_wm_o | output | 1 | Watermark condition |
| tx_empty_evt_o | output | 1 | Drained-to-zero pulse |
| ovf_o | output | 1 | Dropped-write pulse |

## Verification
The bench builds the block with its default 16-entry, 8-bit configuration. This is small enough to fill the queue to capacity and past it, and to drain it completely, under every one of the eight threshold codes. That walks the watermark through its rise and fall at all four threshold levels, including the shared value of the five aliased codes. With a 16-deep queue, the full-with-simultaneous-pop case, the overflow drop and the clear-during-write case are also each reached within a few dozen cycles.

// File: rtl/tfw_pkg.sv
package tfw_pkg;

  typedef enum logic [2:0] {
    THR_ONE     = 3'd0,
    THR_QUARTER = 3'd1,
    THR_HALF    = 3'd2,
    THR_3QTR    = 3'd3
  } thr_code_e;

  // Threshold level for a code; codes above THR_3QTR alias to three quarters.
  function automatic int thr_entries(input logic [2:0] code, input int depth);
    case (code)
      THR_ONE:     return 1;
      THR_QUARTER: return depth / 4;
      THR_HALF:    return depth / 2;
      default:     return (3 * depth) / 4;
    endcase
  endfunction

endpackage

// File: rtl/tfw_store.sv
// Byte storage: synchronous write, asynchronous read (distributed RAM style).
module tfw_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/tfw_ptrs.sv
// Read/write pointers and fill level. DEPTH must be a power of two.
module tfw_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [LW-1:0] level
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/tfw_flags.sv
// Registered status flags and event outputs, derived from the next level.
module tfw_flags #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic          drop,
  input  logic [LW-1:0] level_cur,
  input  logic [LW-1:0] thr_lvl,
  output logic          full,
  output logic          empty,
  output logic          wm,
  output logic          empty_evt,
  output logic          ovf
);

  logic [LW-1:0] lvl_next;

  always_comb begin
    if (clear) lvl_next = '0;
    else       lvl_next = level_cur + LW'(push) - LW'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full      <= 1'b0;
      empty     <= 1'b1;
      wm        <= 1'b0;
      empty_evt <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      full      <= (lvl_next == LW'(DEPTH));
      empty     <= (lvl_next == '0);
      wm        <= (lvl_next >= thr_lvl) ? (wm | (push & ~clear)) : 1'b0;
      empty_evt <= ~clear & pop & ~push & (level_cur == LW'(1));
      ovf       <= drop;
    end
  end

endmodule

// File: rtl/tx_fifo_wm.sv
module tx_fifo_wm #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_enable_i,
  input  logic              wdata_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fctl_we_i,
  input  logic              fctl_txrst_i,
  input  logic [2:0]        fctl_thr_i,
  input  logic              pop_ready_i,
  output logic              pop_valid_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [LW-1:0]     level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              tx_wm_o,
  output logic              tx_empty_evt_o,
  output logic              ovf_o
);

  logic          clear;
  logic          pop_fire;
  logic          push_acc;
  logic          drop;
  logic [2:0]    thr_code_q;
  logic [2:0]    thr_code_n;
  logic [LW-1:0] thr_lvl;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  assign clear       = fctl_we_i & fctl_txrst_i;
  assign pop_valid_o = tx_enable_i & ~empty_o;
  assign pop_fire    = pop_valid_o & pop_ready_i;
  assign push_acc    = wdata_we_i & ~clear & (~full_o | pop_fire);
  assign drop        = wdata_we_i & ~clear & ~push_acc;

  assign thr_code_n = fctl_we_i ? fctl_thr_i : thr_code_q;
  assign thr_lvl    = LW'(tfw_pkg::thr_entries(thr_code_n, DEPTH));

  always_ff @(posedge clk) begin
    if (rst) thr_code_q <= tfw_pkg::THR_ONE;
    else     thr_code_q <= thr_code_n;
  end

  tfw_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (push_acc),
    .waddr (wr_ptr),
    .wdata (wdata_i),
    .raddr (rd_ptr),
    .rdata (pop_data_o)
  );

  tfw_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk    (clk),
    .rst    (rst),
    .clear  (clear),
    .push   (push_acc),
    .pop    (pop_fire),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .level  (level_o)
  );

  tfw_flags #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .push      (push_acc),
    .pop       (pop_fire),
    .drop      (drop),
    .level_cur (level_o),
    .thr_lvl   (thr_lvl),
    .full      (full_o),
    .empty     (empty_o),
    .wm        (tx_wm_o),
    .empty_evt (tx_empty_evt_o),
    .ovf       (ovf_o)
  );

endmodule

// File: rtl/tfw_checker.sv
module tfw_checker #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_enable_i,
  input logic          wdata_we_i,
  input logic          fctl_we_i,
  input logic          fctl_txrst_i,
  input logic          pop_valid_o,
  input logic [LW-1:0] level_o,
  input logic          full_o,
  input logic          empty_o,
  input logic          tx_wm_o,
  input logic          tx_empty_evt_o,
  input logic          ovf_o
);

  assert_single_step_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(fctl_we_i && fctl_txrst_i) |->
      (level_o == $past(level_o)) || (level_o == $past(level_o) + LW'(1)) ||
      (level_o + LW'(1) == $past(level_o)));

  assert_drop_when_full_R2: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> $past(full_o) && (level_o == $past(level_o)));

  assert_full_level_R3: assert property (@(posedge clk) disable iff (rst)
    full_o |-> (level_o == LW'(DEPTH)));

  assert_empty_level_R4: assert property (@(posedge clk) disable iff (rst)
    empty_o == (level_o == '0));

  assert_empty_event_R5: assert property (@(posedge clk) disable iff (rst)
    tx_empty_evt_o |-> empty_o && ($past(level_o) == LW'(1)));

  assert_wm_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_wm_o) |-> $past(wdata_we_i));

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(fctl_we_i && fctl_txrst_i) |-> (level_o == '0) && !tx_empty_evt_o);

  assert_pop_gate_R9: assert property (@(posedge clk) disable iff (rst)
    pop_valid_o |-> tx_enable_i && !empty_o);

endmodule

bind tx_fifo_wm tfw_checker #(.DEPTH(DEPTH)) u_tfw_checker (
  .clk            (clk),
  .rst            (rst),
  .tx_enable_i    (tx_enable_i),
  .wdata_we_i     (wdata_we_i),
  .fctl_we_i      (fctl_we_i),
  .fctl_txrst_i   (fctl_txrst_i),
  .pop_valid_o    (pop_valid_o),
  .level_o        (level_o),
  .full_o         (full_o),
  .empty_o        (empty_o),
  .tx_wm_o        (tx_wm_o),
  .tx_empty_evt_o (tx_empty_evt_o),
  .ovf_o          (ovf_o)
);

// File: tb/test_tx_fifo_wm.sv
module test_tx_fifo_wm;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_enable_i = 1'b0;
  logic       wdata_we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       fctl_we_i = 1'b0;
  logic       fctl_txrst_i = 1'b0;
  logic [2:0] fctl_thr_i = '0;
  logic       pop_ready_i = 1'b0;
  logic       pop_valid_o;
  logic [7:0] pop_data_o;
  logic [4:0] level_o;
  logic       full_o, empty_o, tx_wm_o, tx_empty_evt_o, ovf_o;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  // reference model state
  logic [7:0] mdl [DEPTH];
  int mh = 0, mc = 0, mcode = 0;
  bit mwm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_fifo_wm i_tx_fifo_wm (
    .clk, .rst, .tx_enable_i, .wdata_we_i, .wdata_i, .fctl_we_i, .fctl_txrst_i,
    .fctl_thr_i, .pop_ready_i, .pop_valid_o, .pop_data_o, .level_o, .full_o,
    .empty_o, .tx_wm_o, .tx_empty_evt_o, .ovf_o
  );

  task automatic chk(input string tag, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int thr_of(input int code);
    if (code == 0) return 1;
    if (code == 1) return 4;
    if (code == 2) return 8;
    return 12;
  endfunction

  // One cycle: called at a falling edge, returns at the next falling edge.
  task automatic step(input bit we, input logic [7:0] d, input bit rdy, input bit en,
                      input bit fwe, input bit frst, input int code);
    bit vld, fire, clr, acc, drop, evt;
    int oldc;
    wdata_we_i = we; wdata_i = d; pop_ready_i = rdy; tx_enable_i = en;
    fctl_we_i = fwe; fctl_txrst_i = frst; fctl_thr_i = 3'(code);
    #1;
    vld = en && (mc > 0);
    chk("R9 pop_valid", pop_valid_o, vld);
    if (vld && rdy) chk("R9 pop_data order", pop_data_o, mdl[mh]);
    fire = vld && rdy;
    clr  = fwe && frst;
    acc  = we && !clr && (mc < DEPTH || fire);
    drop = we && !clr && !acc;
    oldc = mc;
    evt  = !clr && fire && !acc && (oldc == 1);
    if (fwe) mcode = code;
    if (clr) begin
      mc = 0; mh = 0;
    end else begin
      if (acc) mdl[(mh + mc) % DEPTH] = d;
      if (fire) mh = (mh + 1) % DEPTH;
      mc = mc + int'(acc) - int'(fire);
    end
    mwm = (mc >= thr_of(mcode)) ? (mwm | acc) : 1'b0;
    @(negedge clk);
    chk(clr ? "R8 level after clear" : (acc && fire ? "R10 level" : "R1 level"), level_o, mc);
    chk("R3 full", full_o, mc == DEPTH);
    chk("R4 empty", empty_o, mc == 0);
    chk("R6 R7 watermark", tx_wm_o, mwm);
    chk("R5 empty event", tx_empty_evt_o, evt);
    chk("R2 overflow", ovf_o, drop);
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 0, 0, 0, mcode);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 level", level_o, 0);
    chk("R11 empty", empty_o, 1);
    chk("R11 full", full_o, 0);
    chk("R11 wm", tx_wm_o, 0);
    chk("R11 evt", tx_empty_evt_o, 0);
    chk("R11 ovf", ovf_o, 0);
    // R6 default code 0: one write raises watermark
    step(1, 8'hA5, 0, 0, 0, 0, 0);
    chk("R6 reset code gives threshold 1", tx_wm_o, 1);
    step(0, 8'h00, 1, 1, 0, 0, 0);

    for (int code = 0; code < 8; code++) begin
      step(0, 8'h00, 0, 0, 1, 1, code);               // R8 clear + load code
      for (int k = 0; k < DEPTH + 2; k++)             // fill past capacity (R2)
        step(1, 8'((code << 5) + k), 0, 0, 0, 0, code);
      step(1, 8'hEE, 1, 1, 0, 0, code);               // R10 write to full with pop
      step(0, 8'h00, 1, 0, 0, 0, code);               // R9 enable low: no pop
      for (int k = 0; k < DEPTH + 1; k++)             // drain (R5, R7 fall)
        step(0, 8'h00, 1, 1, 0, 0, code);
      idle();
    end

    // mixed traffic at a mid level
    for (int k = 0; k < 5; k++) step(1, 8'(k + 8'h40), 0, 0, 0, 0, 1);
    for (int k = 0; k < 6; k++) step(1, 8'(k + 8'h50), 1, 1, 0, 0, 1); // R10
    step(0, 8'h00, 1, 1, 0, 0, 1);
    // R8 clear with a simultaneous write and pop: no overflow, no event
    step(1, 8'h77, 1, 1, 1, 1, 2);
    chk("R8 cleared", level_o, 0);
    // R5 single byte drain
    step(1, 8'h11, 0, 0, 0, 0, 2);
    step(0, 8'h00, 1, 1, 0, 0, 2);
    chk("R5 single drain event", tx_empty_evt_o, 1);
    idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule